// File: doc/BRIEF.md
# ADC Ramp Pattern Checker

This block watches a single ADC sample lane while the converter sends a counting ramp as its test pattern. It lets the capture timing be judged without knowing where the ramp starts. Once enabled, the block waits for a sample of value zero and locks onto it. From then on it predicts every following sample as one more than the last prediction. It keeps a saturating count of the valid samples that miss that prediction.

The locked flag and the mismatch count are separate outputs. A lane that never produced a zero therefore reads as unlocked, and is not mistaken for a clean lane with a count of zero. A fresh measurement starts only when enable goes low and then high again. The I and Q lanes each use their own instance.

Top module: `ramp_lane_checker`

## Requirements
- R1: One clock edge after enable is sampled low, locked reads 0 and errCount reads 0. Both stay there for as long as enable stays low.
- R2: With enable high, locked stays 0 until a valid sample equal to zero is taken. It reads 1 from the cycle after that sample and holds while enable stays high.
- R3: Once locked, each valid sample is compared against the expected value. The expected value is 1 for the first sample after the locking zero and rises by one per valid sample after that. A mismatching sample raises errCount by exactly one, visible the cycle after the sample.
- R4: The expected value advances along its own sequence, whatever was received. After one corrupted sample, the following correct ramp samples add no further errors.
- R5: The expected value wraps from all ones (2^SAMPLE_W-1) to zero. A ramp that rolls over adds no error.
- R6: errCount stops at 2^CNT_W-1 and does not wrap while mismatches continue.
- R7: Cycles with sampleValid low change neither errCount nor the expected sequence, and they cannot cause a lock.
- R8: While locked, a later zero sample does not re-seed or reset the checker. It is treated as an ordinary sample, and counts as an error unless zero was expected. errCount is 0 whenever locked is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rstN | input | 1 | Asynchronous active-low reset |
| enable | input | 1 | High to measure; a low-to-high toggle restarts the measurement |
| sampleValid | input | 1 | Qualifies sampleData this cycle |
| sampleData | input | SAMPLE_W | Sample from the ADC lane |
| locked | output | 1 | Checker has seen its zero sample and is tracking |
| errCount | output | CNT_W | Saturating count of mismatching samples since lock |

## Verification
The inputs pass through no register before the decision, so every result is due exactly one edge after the cycle that carries the stimulus. This covers a lock after a valid zero, a count step after a mismatch, and the clear after enable drops. The bench drives each cycle just after a rising edge and advances a bench model by that cycle's input. It then compares locked and errCount one time step after the next rising edge, so each compare lands on the edge where the result is due. The random mix of good, corrupted and idle samples and the directed rollover, saturation and re-arm runs all use this same one-edge rule.

// File: rtl/ramp_chk_pkg.sv
package ramp_chk_pkg;

  // Strobes issued by the control to the datapath each cycle
  typedef struct packed {
    logic clear;     // drop everything back to the idle state
    logic lockNow;   // zero sample seen while hunting: seed the sequence
    logic checkNow;  // tracking and a valid sample is present: compare
  } chkStrobes_t;

  typedef enum logic {
    ST_HUNT  = 1'b0,
    ST_TRACK = 1'b1
  } chkState_t;

endpackage

// File: rtl/ramp_chk_ctrl.sv
module ramp_chk_ctrl
  import ramp_chk_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        enable,
  input  logic        sampleValid,
  input  logic        sampleIsZero,
  output chkStrobes_t strobes,
  output logic        lockedQ
);

  chkState_t state;
  chkState_t nextState;

  always_comb begin
    strobes   = '0;
    nextState = state;
    if (!enable) begin
      strobes.clear = 1'b1;
      nextState     = ST_HUNT;
    end else if (sampleValid) begin
      case (state)
        ST_HUNT: begin
          if (sampleIsZero) begin
            strobes.lockNow = 1'b1;
            nextState       = ST_TRACK;
          end
        end
        ST_TRACK: strobes.checkNow = 1'b1;
        default:  nextState = ST_HUNT;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_HUNT;
    else       state <= nextState;
  end

  assign lockedQ = (state == ST_TRACK);

  // R1: a low enable always leaves the checker unlocked
  a_r1_disable_unlocks: assert property (@(posedge clk) disable iff (!rstN)
    !enable |=> !lockedQ);

  // R2: lock appears only after a valid zero while enabled
  a_r2_lock_cause: assert property (@(posedge clk) disable iff (!rstN)
    $rose(lockedQ) |-> $past(enable && sampleValid && sampleIsZero));

  // R8: once locked, only a low enable can drop the lock
  a_r8_lock_holds: assert property (@(posedge clk) disable iff (!rstN)
    (lockedQ && enable) |=> lockedQ);

  // Strobes never overlap
  a_r3_strobe_onehot: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes));

endmodule

// File: rtl/ramp_chk_datapath.sv
module ramp_chk_datapath
  import ramp_chk_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  chkStrobes_t         strobes,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic                sampleIsZero,
  output logic [CNT_W-1:0]    errCount
);

  localparam logic [CNT_W-1:0]    CNT_MAX  = {CNT_W{1'b1}};
  localparam logic [SAMPLE_W-1:0] SEED_VAL = SAMPLE_W'(1);

  logic [SAMPLE_W-1:0] expected;
  logic                mismatch;
  logic                countSat;

  assign sampleIsZero = (sampleData == '0);
  assign mismatch     = (sampleData != expected);
  assign countSat     = (errCount == CNT_MAX);

  // Prediction register: follows its own sequence, never the input
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                 expected <= '0;
    else if (strobes.clear)    expected <= '0;
    else if (strobes.lockNow)  expected <= SEED_VAL;
    else if (strobes.checkNow) expected <= expected + SEED_VAL;
  end

  // Saturating mismatch counter
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              errCount <= '0;
    else if (strobes.clear) errCount <= '0;
    else if (strobes.checkNow && mismatch && !countSat)
                            errCount <= errCount + CNT_W'(1);
  end

  // R6: a full counter stays full until cleared
  a_r6_saturate: assert property (@(posedge clk) disable iff (!rstN)
    (countSat && !strobes.clear) |=> (errCount == CNT_MAX));

  // R3: the count moves by at most one per cycle unless cleared
  a_r3_single_step: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.clear |=> (errCount == $past(errCount)) ||
                       (errCount == $past(errCount) + CNT_W'(1)));

  // R7: without a valid comparison the prediction does not move
  a_r7_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !(strobes.clear || strobes.lockNow || strobes.checkNow) |=> $stable(expected));

  // R1: a clear empties the count
  a_r1_clear_count: assert property (@(posedge clk) disable iff (!rstN)
    strobes.clear |=> (errCount == '0));

endmodule

// File: rtl/ramp_lane_checker.sv
module ramp_lane_checker
  import ramp_chk_pkg::*;
#(
  parameter int SAMPLE_W = 12,
  parameter int CNT_W    = 16
) (
  input  logic                clk,
  input  logic                rstN,
  input  logic                enable,
  input  logic                sampleValid,
  input  logic [SAMPLE_W-1:0] sampleData,
  output logic                locked,
  output logic [CNT_W-1:0]    errCount
);

  chkStrobes_t strobes;
  logic        sampleIsZero;

  ramp_chk_ctrl u_ctrl (
    .clk          (clk),
    .rstN         (rstN),
    .enable       (enable),
    .sampleValid  (sampleValid),
    .sampleIsZero (sampleIsZero),
    .strobes      (strobes),
    .lockedQ      (locked)
  );

  ramp_chk_datapath #(
    .SAMPLE_W (SAMPLE_W),
    .CNT_W    (CNT_W)
  ) u_dp (
    .clk          (clk),
    .rstN         (rstN),
    .strobes      (strobes),
    .sampleData   (sampleData),
    .sampleIsZero (sampleIsZero),
    .errCount     (errCount)
  );

  // R8: an unlocked checker never reports errors
  a_r8_unlocked_clean: assert property (@(posedge clk) disable iff (!rstN)
    !locked |-> (errCount == '0));

endmodule

// File: tb/ramp_lane_checker_test.sv
`timescale 1ns/1ps
module ramp_lane_checker_test;

  localparam int SW   = 12;
  localparam int CW   = 6;
  localparam int SMAX = (1 << SW) - 1;
  localparam int CMAX = (1 << CW) - 1;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          enable = 1'b0;
  logic          sampleValid = 1'b0;
  logic [SW-1:0] sampleData = '0;
  logic          locked;
  logic [CW-1:0] errCount;

  int checks = 0;
  int fails  = 0;

  // bench model
  bit mLocked = 1'b0;
  int mExp = 0;
  int mCnt = 0;

  always #2.5 clk = ~clk;  // 200 MHz

  ramp_lane_checker #(.SAMPLE_W(SW), .CNT_W(CW)) uut (
    .clk(clk), .rstN(rstN), .enable(enable), .sampleValid(sampleValid),
    .sampleData(sampleData), .locked(locked), .errCount(errCount)
  );

  function automatic int nextExp(int e);
    return (e + 1) & SMAX;
  endfunction

  task automatic modelStep(bit en, bit v, int d);
    if (!en) begin
      mLocked = 1'b0; mExp = 0; mCnt = 0;
    end else if (v) begin
      if (!mLocked) begin
        if (d == 0) begin mLocked = 1'b1; mExp = 1; end
      end else begin
        if (d != mExp && mCnt != CMAX) mCnt = mCnt + 1;
        mExp = nextExp(mExp);
      end
    end
  endtask

  task automatic checkOut(string tag);
    checks++;
    if (locked !== mLocked) begin
      fails++;
      $display("FAIL %s locked actual=%0b expected=%0b", tag, locked, mLocked);
    end
    checks++;
    if (int'(errCount) != mCnt) begin
      fails++;
      $display("FAIL %s errCount actual=%0d expected=%0d", tag, errCount, mCnt);
    end
  endtask

  // drive one cycle, then compare one edge later
  task automatic step(bit en, bit v, int d, string tag);
    enable = en; sampleValid = v; sampleData = SW'(d);
    @(posedge clk); #1;
    modelStep(en, v, d);
    checkOut(tag);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    void'($urandom(32'd7));
    repeat (3) @(posedge clk);
    #1;
    checkOut("R1 reset");
    rstN = 1'b1;

    // R1: disabled, zeros ignored
    step(0, 1, 0, "R1 disabled zero");
    step(0, 1, 5, "R1 disabled");

    // R2 / R7: no lock on nonzero or on invalid zero
    step(1, 1, 7, "R2 nonzero no lock");
    step(1, 0, 0, "R7 invalid zero no lock");
    step(1, 1, 3, "R2 still hunting");
    step(1, 1, 0, "R2 lock on zero");
    step(1, 1, 1, "R3 first match");
    step(1, 1, 2, "R3 match");
    step(1, 1, 9, "R3 mismatch");
    step(1, 1, 4, "R4 resync via sequence");
    step(1, 0, 77, "R7 idle");
    step(1, 1, 5, "R7 sequence held");
    step(1, 1, 0, "R8 zero while locked");
    step(1, 1, 7, "R8 stays locked");

    // R1: re-arm by toggling enable
    step(0, 0, 0, "R1 enable low clears");
    step(0, 1, 0, "R1 held clear");
    step(1, 1, 0, "R2 relock after rearm");

    // R5: full rollover
    for (int i = 1; i <= SMAX; i++) step(1, 1, i, "R5 ramp");
    step(1, 1, 0, "R5 wrap to zero");
    step(1, 1, 1, "R5 after wrap");

    // Random mix
    step(0, 0, 0, "R1 clear before random");
    step(1, 1, 0, "R2 lock random");
    for (int i = 0; i < 3000; i++) begin
      int r = $urandom % 10;
      int d;
      bit v = (r != 0);
      d = mExp;
      if (r == 1) d = mExp ^ (1 + ($urandom % SMAX));
      if (r == 0) d = $urandom % (SMAX + 1);
      step(1, v, d & SMAX, "R3 random");
    end

    // R6: saturation
    step(0, 0, 0, "R1 clear before sat");
    step(1, 1, 0, "R2 lock sat");
    for (int i = 0; i < CMAX + 10; i++) step(1, 1, nextExp(mExp), "R6 saturate");
    step(1, 1, mExp, "R6 match at max");
    step(0, 0, 0, "R1 clear after sat");

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule